// File: doc/BRIEF.md
# SPI Status Flag Register Unit

This unit gathers single-cycle event pulses and level conditions from an SPI controller and presents them as one 32-bit read-only status word. The word is combinational from internal state, so it is always visible on `stat_rdata`. A one-cycle `stat_rd` strobe marks the read that the software performs.

Each bit follows one of three clearing policies:
- **Clear on read.** The error, event and FIFO-transition flags are sticky and clear on a status read.
- **Clear on write.** The transmit-ready, transmit-path-empty and end-of-buffer bits clear on a write to the related data or counter register.
- **Pure level.** The enable, pointer-error and buffer-empty/full bits follow their inputs, one cycle later.

The FIFO flags record a change of state (into full, into empty, across the threshold), not the level. The unit derives FIFO full, empty and threshold conditions from the FIFO fill levels and the programmed thresholds. The shifter, the FIFOs and the DMA counters are outside the unit.

Top module: `spi_flag_unit`

## Requirements
- R1: While reset is asserted and right after it, `stat_rdata` equals 0x000000F0 (bits 7..4 set, all others clear) when the buffer counter zero inputs are high. Bits 23..17, 15..14 always read 0.
- R2: A one-cycle pulse on an event input sets its sticky bit after the next clock edge: mode fault bit 2, underrun bit 10, chip-select rise bit 8, frame error bit 12, CRC error bit 13, compare match bit 11. The bit stays set until a cycle with `stat_rd` high, and reads 0 after it.
- R3: When an event pulse and `stat_rd` occur in the same cycle, the event's bit is set after that edge and is reported by the next read.
- R4: The word presented during a `stat_rd` cycle contains every sticky bit set before that cycle; the clear takes effect only at the following edge.
- R5: Bit 3 (overrun) sets when `rdr_load` pulses while an earlier load has not been consumed by `rdr_read`. A load in the same cycle as a read does not count as an overrun. Bit 3 clears on read.
- R6: Bits 29 (RX at/above threshold, level >= threshold), 28 (RX full, level == FIFO_DEPTH) and 27 (RX empty, level == 0) set only when their condition goes from false to true. They clear on read and do not reset while the condition merely stays true.
- R7: Bits 26 (TX at/below threshold, level <= threshold), 25 (TX full) and 24 (TX empty) set only on the false-to-true change of their condition and clear on read.
- R8: Bit 9 (transmit path empty) clears on `tdr_write` and has priority over any set in that cycle. It sets when the data path is empty, `shift_idle` is high and `gap_done` is high. The data path is empty when bit 1 is set with FIFOs off, or when the TX level is 0 with FIFOs on.
- R9: With FIFOs off, bit 1 (transmit ready) is 0 while `spi_en` is low. It sets on the rising edge of `spi_en` and on `tdr_to_shift`, and clears on `tdr_write`. With FIFOs on it reads 1 exactly when the TX level is below FIFO_DEPTH.
- R10: With FIFOs off, bit 0 (receive ready) sets on `rdr_load` and clears on `rdr_read`. With FIFOs on it reads 1 exactly when the RX level is nonzero.
- R11: Bits 5 (end of TX buffer) and 4 (end of RX buffer) reset to 1. Each sets while its counter zero input is high and clears on its counter write strobe; the write wins over a set in the same cycle.
- R12: Bit 16 follows `spi_en`, bits 31/30 follow the RX/TX pointer error inputs, and bits 7/6 are high when both the counter and next-counter zero inputs of TX/RX are high. Each reflects its inputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFO mode selected |
| spi_en | input | 1 | Controller enabled |
| rdr_load | input | 1 | Receive data register loaded from shifter (pulse) |
| rdr_read | input | 1 | Receive data register read (pulse) |
| tdr_write | input | 1 | Transmit data register written (pulse) |
| tdr_to_shift | input | 1 | Transmit data moved into shifter (pulse) |
| shift_idle | input | 1 | Shifter holds no data |
| gap_done | input | 1 | Inter-transfer delay expired |
| ev_modf | input | 1 | Mode fault event |
| ev_underrun | input | 1 | Underrun event |
| ev_cs_rise | input | 1 | Chip-select rising edge event |
| ev_frame_err | input | 1 | Client frame error event |
| ev_crc_err | input | 1 | CRC error event |
| ev_match | input | 1 | Compare match event |
| rx_level | input | LW | RX FIFO fill level |
| rx_thres | input | LW | RX FIFO threshold |
| tx_level | input | LW | TX FIFO fill level |
| tx_thres | input | LW | TX FIFO threshold |
| rx_ptr_err | input | 1 | RX FIFO pointer error level |
| tx_ptr_err | input | 1 | TX FIFO pointer error level |
| tx_cnt_zero | input | 1 | TX transfer counter is zero |
| tx_ncnt_zero | input | 1 | TX next counter is zero |
| rx_cnt_zero | input | 1 | RX transfer counter is zero |
| rx_ncnt_zero | input | 1 | RX next counter is zero |
| tx_cnt_wr | input | 1 | TX counter or next-counter written (pulse) |
| rx_cnt_wr | input | 1 | RX counter or next-counter written (pulse) |
| stat_rd | input | 1 | Status word read strobe |
| stat_rdata | output | 32 | Status word |

## Verification
The hardest situations to reach are the ones where two actions meet in one cycle:
- an event pulse arriving together with a clearing status read;
- a receive load coinciding with a receive read;
- a counter write coinciding with a zero counter.

The bench drives these pairs in the same cycle on purpose and checks the word one edge later.

The transition-only FIFO flags are also hard to exercise. For them, the bench walks the fill levels through chosen values: below, at and above threshold, then full, then empty. It reads in between to prove that a condition which stays true does not re-set its flag.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  localparam int WORD_W = 32;

  // status word bit positions
  localparam int B_RDRF  = 0;
  localparam int B_TDRE  = 1;
  localparam int B_MODF  = 2;
  localparam int B_OVR   = 3;
  localparam int B_ENDRX = 4;
  localparam int B_ENDTX = 5;
  localparam int B_RXBF  = 6;
  localparam int B_TXBE  = 7;
  localparam int B_CSR   = 8;
  localparam int B_TXEMP = 9;
  localparam int B_UND   = 10;
  localparam int B_CMP   = 11;
  localparam int B_FRM   = 12;
  localparam int B_CRC   = 13;
  localparam int B_EN    = 16;
  localparam int B_TXE   = 24;
  localparam int B_TXF   = 25;
  localparam int B_TXT   = 26;
  localparam int B_RXE   = 27;
  localparam int B_RXF   = 28;
  localparam int B_RXT   = 29;
  localparam int B_TXPE  = 30;
  localparam int B_RXPE  = 31;

  // FIFO condition indexes
  localparam int C_RXT = 0;
  localparam int C_RXF = 1;
  localparam int C_RXE = 2;
  localparam int C_TXT = 3;
  localparam int C_TXF = 4;
  localparam int C_TXE = 5;
  localparam int N_COND = 6;

  // sticky (clear-on-read) flag indexes
  localparam int S_MODF = 0;
  localparam int S_OVR  = 1;
  localparam int S_CSR  = 2;
  localparam int S_UND  = 3;
  localparam int S_CMP  = 4;
  localparam int S_FRM  = 5;
  localparam int S_CRC  = 6;
  localparam int S_TXE  = 7;
  localparam int S_TXF  = 8;
  localparam int S_TXT  = 9;
  localparam int S_RXE  = 10;
  localparam int S_RXF  = 11;
  localparam int S_RXT  = 12;
  localparam int N_STICKY = 13;

  function automatic logic lvl_at_or_above(input int lvl, input int thr);
    return lvl >= thr;
  endfunction

  function automatic logic lvl_at_or_below(input int lvl, input int thr);
    return lvl <= thr;
  endfunction

  function automatic logic lvl_full(input int lvl, input int depth);
    return lvl >= depth;
  endfunction

  function automatic logic lvl_empty(input int lvl);
    return lvl == 0;
  endfunction

  // next value of a sticky bit: set wins over clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // next value of a write-cleared bit: clear wins over set
  function automatic logic wrclr_next(input logic cur, input logic set, input logic clr);
    return ~clr & (set | cur);
  endfunction
endpackage

// File: rtl/sfl_sticky_bank.sv
module sfl_sticky_bank #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  import sfl_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_r;
    always_ff @(posedge clk) begin
      if (!rst_n) flag_r <= 1'b0;
      else        flag_r <= sticky_next(flag_r, set_i[g], clr_i);
    end
    assign flag_o[g] = flag_r;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_o[g]);                        // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i[g]) |=> !flag_o[g]);          // R2
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[g] && !clr_i) |=> flag_o[g]);          // R2
  end
endmodule

// File: rtl/sfl_fifo_watch.sv
module sfl_fifo_watch #(
  parameter int FIFO_DEPTH = 16,
  parameter int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] rx_thres,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] tx_thres,
  output logic [5:0]    cond_rise,
  output logic          rx_has_data,
  output logic          tx_has_room,
  output logic          tx_drained
);
  import sfl_pkg::*;

  logic [N_COND-1:0] cond;

  always_comb begin
    cond[C_RXT] = lvl_at_or_above(int'(rx_level), int'(rx_thres));
    cond[C_RXF] = lvl_full(int'(rx_level), FIFO_DEPTH);
    cond[C_RXE] = lvl_empty(int'(rx_level));
    cond[C_TXT] = lvl_at_or_below(int'(tx_level), int'(tx_thres));
    cond[C_TXF] = lvl_full(int'(tx_level), FIFO_DEPTH);
    cond[C_TXE] = lvl_empty(int'(tx_level));
  end

  assign rx_has_data = ~cond[C_RXE];
  assign tx_has_room = ~cond[C_TXF];
  assign tx_drained  = cond[C_TXE];

  // prev starts high so no flag appears unless the condition was seen false
  for (genvar g = 0; g < N_COND; g++) begin : g_det
    logic prev_r;
    always_ff @(posedge clk) begin
      if (!rst_n) prev_r <= 1'b1;
      else        prev_r <= cond[g];
    end
    assign cond_rise[g] = cond[g] & ~prev_r;

    AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cond_rise[g] |-> !$past(cond[g]));             // R6
  end
endmodule

// File: rtl/sfl_xfer_track.sv
module sfl_xfer_track (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_en,
  input  logic fifo_en,
  input  logic tx_drained,
  input  logic rdr_load,
  input  logic rdr_read,
  input  logic tdr_write,
  input  logic tdr_to_shift,
  input  logic shift_idle,
  input  logic gap_done,
  input  logic tx_cnt_zero,
  input  logic rx_cnt_zero,
  input  logic tx_cnt_wr,
  input  logic rx_cnt_wr,
  output logic tdre_o,
  output logic txempty_o,
  output logic rdr_full_o,
  output logic ovr_evt_o,
  output logic endtx_o,
  output logic endrx_o
);
  import sfl_pkg::*;

  logic en_q, tdre_q, txe_q, rdr_full_q, endtx_q, endrx_q;
  logic en_rise, tdre_set, path_idle;

  assign en_rise   = spi_en & ~en_q;
  assign tdre_set  = en_rise | tdr_to_shift;
  assign path_idle = (fifo_en ? tx_drained : tdre_q) & shift_idle & gap_done;
  assign ovr_evt_o = rdr_load & rdr_full_q & ~rdr_read;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      tdre_q     <= 1'b0;
      txe_q      <= 1'b0;
      rdr_full_q <= 1'b0;
      endtx_q    <= 1'b1;
      endrx_q    <= 1'b1;
    end else begin
      en_q       <= spi_en;
      tdre_q     <= spi_en & wrclr_next(tdre_q, tdre_set, tdr_write);
      txe_q      <= wrclr_next(txe_q, path_idle, tdr_write);
      rdr_full_q <= rdr_load | (rdr_full_q & ~rdr_read);
      endtx_q    <= wrclr_next(endtx_q, tx_cnt_zero, tx_cnt_wr);
      endrx_q    <= wrclr_next(endrx_q, rx_cnt_zero, rx_cnt_wr);
    end
  end

  assign tdre_o     = tdre_q;
  assign txempty_o  = txe_q;
  assign rdr_full_o = rdr_full_q;
  assign endtx_o    = endtx_q;
  assign endrx_o    = endrx_q;

  AST_TDR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tdr_write |=> (!txempty_o && !tdre_o));            // R8
  AST_DISABLED_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_en |=> !tdre_o);                              // R9
  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    rdr_load |=> rdr_full_o);                          // R10
  AST_CNT_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt_wr |=> !endtx_o);                           // R11
  AST_OVR_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt_o |-> !rdr_read);                          // R5
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit #(
  parameter int FIFO_DEPTH = 16,
  parameter int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          spi_en,
  input  logic          rdr_load,
  input  logic          rdr_read,
  input  logic          tdr_write,
  input  logic          tdr_to_shift,
  input  logic          shift_idle,
  input  logic          gap_done,
  input  logic          ev_modf,
  input  logic          ev_underrun,
  input  logic          ev_cs_rise,
  input  logic          ev_frame_err,
  input  logic          ev_crc_err,
  input  logic          ev_match,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] rx_thres,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] tx_thres,
  input  logic          rx_ptr_err,
  input  logic          tx_ptr_err,
  input  logic          tx_cnt_zero,
  input  logic          tx_ncnt_zero,
  input  logic          rx_cnt_zero,
  input  logic          rx_ncnt_zero,
  input  logic          tx_cnt_wr,
  input  logic          rx_cnt_wr,
  input  logic          stat_rd,
  output logic [31:0]   stat_rdata
);
  import sfl_pkg::*;

  // named internal events
  logic [5:0]          fifo_rise;
  logic                rx_has_data, tx_has_room, tx_drained;
  logic                tdre_nf, txempty, rdr_full, ovr_evt, endtx, endrx;
  logic [N_STICKY-1:0] sticky_set, sticky_q;

  // registered level conditions
  logic lv_en, lv_rxpe, lv_txpe, lv_txbe, lv_rxbf, lv_rxdata, lv_txroom;

  sfl_fifo_watch #(.FIFO_DEPTH(FIFO_DEPTH), .LW(LW)) u_watch (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_level    (rx_level),
    .rx_thres    (rx_thres),
    .tx_level    (tx_level),
    .tx_thres    (tx_thres),
    .cond_rise   (fifo_rise),
    .rx_has_data (rx_has_data),
    .tx_has_room (tx_has_room),
    .tx_drained  (tx_drained)
  );

  sfl_xfer_track u_xfer (
    .clk          (clk),
    .rst_n        (rst_n),
    .spi_en       (spi_en),
    .fifo_en      (fifo_en),
    .tx_drained   (tx_drained),
    .rdr_load     (rdr_load),
    .rdr_read     (rdr_read),
    .tdr_write    (tdr_write),
    .tdr_to_shift (tdr_to_shift),
    .shift_idle   (shift_idle),
    .gap_done     (gap_done),
    .tx_cnt_zero  (tx_cnt_zero),
    .rx_cnt_zero  (rx_cnt_zero),
    .tx_cnt_wr    (tx_cnt_wr),
    .rx_cnt_wr    (rx_cnt_wr),
    .tdre_o       (tdre_nf),
    .txempty_o    (txempty),
    .rdr_full_o   (rdr_full),
    .ovr_evt_o    (ovr_evt),
    .endtx_o      (endtx),
    .endrx_o      (endrx)
  );

  always_comb begin
    sticky_set         = '0;
    sticky_set[S_MODF] = ev_modf;
    sticky_set[S_OVR]  = ovr_evt;
    sticky_set[S_CSR]  = ev_cs_rise;
    sticky_set[S_UND]  = ev_underrun;
    sticky_set[S_CMP]  = ev_match;
    sticky_set[S_FRM]  = ev_frame_err;
    sticky_set[S_CRC]  = ev_crc_err;
    sticky_set[S_TXE]  = fifo_rise[C_TXE];
    sticky_set[S_TXF]  = fifo_rise[C_TXF];
    sticky_set[S_TXT]  = fifo_rise[C_TXT];
    sticky_set[S_RXE]  = fifo_rise[C_RXE];
    sticky_set[S_RXF]  = fifo_rise[C_RXF];
    sticky_set[S_RXT]  = fifo_rise[C_RXT];
  end

  sfl_sticky_bank #(.N(N_STICKY)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (sticky_set),
    .clr_i  (stat_rd),
    .flag_o (sticky_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lv_en     <= 1'b0;
      lv_rxpe   <= 1'b0;
      lv_txpe   <= 1'b0;
      lv_txbe   <= 1'b1;
      lv_rxbf   <= 1'b1;
      lv_rxdata <= 1'b0;
      lv_txroom <= 1'b0;
    end else begin
      lv_en     <= spi_en;
      lv_rxpe   <= rx_ptr_err;
      lv_txpe   <= tx_ptr_err;
      lv_txbe   <= tx_cnt_zero & tx_ncnt_zero;
      lv_rxbf   <= rx_cnt_zero & rx_ncnt_zero;
      lv_rxdata <= rx_has_data;
      lv_txroom <= tx_has_room;
    end
  end

  always_comb begin
    stat_rdata          = '0;
    stat_rdata[B_RDRF]  = fifo_en ? lv_rxdata : rdr_full;
    stat_rdata[B_TDRE]  = fifo_en ? lv_txroom : tdre_nf;
    stat_rdata[B_MODF]  = sticky_q[S_MODF];
    stat_rdata[B_OVR]   = sticky_q[S_OVR];
    stat_rdata[B_ENDRX] = endrx;
    stat_rdata[B_ENDTX] = endtx;
    stat_rdata[B_RXBF]  = lv_rxbf;
    stat_rdata[B_TXBE]  = lv_txbe;
    stat_rdata[B_CSR]   = sticky_q[S_CSR];
    stat_rdata[B_TXEMP] = txempty;
    stat_rdata[B_UND]   = sticky_q[S_UND];
    stat_rdata[B_CMP]   = sticky_q[S_CMP];
    stat_rdata[B_FRM]   = sticky_q[S_FRM];
    stat_rdata[B_CRC]   = sticky_q[S_CRC];
    stat_rdata[B_EN]    = lv_en;
    stat_rdata[B_TXE]   = sticky_q[S_TXE];
    stat_rdata[B_TXF]   = sticky_q[S_TXF];
    stat_rdata[B_TXT]   = sticky_q[S_TXT];
    stat_rdata[B_RXE]   = sticky_q[S_RXE];
    stat_rdata[B_RXF]   = sticky_q[S_RXF];
    stat_rdata[B_RXT]   = sticky_q[S_RXT];
    stat_rdata[B_TXPE]  = lv_txpe;
    stat_rdata[B_RXPE]  = lv_rxpe;
  end

  AST_MODF_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_modf |=> stat_rdata[B_MODF]);                   // R2
  AST_EN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en |=> stat_rdata[B_EN]);                      // R12
  AST_OVR_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (rdr_load && !rdr_read && stat_rdata[B_RDRF] && !fifo_en) |=> stat_rdata[B_OVR]); // R5
endmodule

// File: tb/spi_flag_unit_test.sv
module spi_flag_unit_test;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [31:0] ALL = 32'hFFFF_FFFF;
  localparam logic [31:0] BASE = 32'h0000_00F0;

  // {pulse[5:0] = match,crc,frame,cs_rise,underrun,modf ; expected extra bits}
  localparam logic [37:0] VEC [8] = '{
    {6'b000001, 32'h0000_0004},
    {6'b000010, 32'h0000_0400},
    {6'b000100, 32'h0000_0100},
    {6'b001000, 32'h0000_1000},
    {6'b010000, 32'h0000_2000},
    {6'b100000, 32'h0000_0800},
    {6'b000011, 32'h0000_0404},
    {6'b111111, 32'h0000_3D04}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic fifo_en, spi_en, rdr_load, rdr_read, tdr_write, tdr_to_shift;
  logic shift_idle, gap_done;
  logic ev_modf, ev_underrun, ev_cs_rise, ev_frame_err, ev_crc_err, ev_match;
  logic [LW-1:0] rx_level, rx_thres, tx_level, tx_thres;
  logic rx_ptr_err, tx_ptr_err, tx_cnt_zero, tx_ncnt_zero, rx_cnt_zero, rx_ncnt_zero;
  logic tx_cnt_wr, rx_cnt_wr, stat_rd;
  logic [31:0] stat_rdata;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  spi_flag_unit #(.FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .spi_en(spi_en),
    .rdr_load(rdr_load), .rdr_read(rdr_read), .tdr_write(tdr_write),
    .tdr_to_shift(tdr_to_shift), .shift_idle(shift_idle), .gap_done(gap_done),
    .ev_modf(ev_modf), .ev_underrun(ev_underrun), .ev_cs_rise(ev_cs_rise),
    .ev_frame_err(ev_frame_err), .ev_crc_err(ev_crc_err), .ev_match(ev_match),
    .rx_level(rx_level), .rx_thres(rx_thres), .tx_level(tx_level), .tx_thres(tx_thres),
    .rx_ptr_err(rx_ptr_err), .tx_ptr_err(tx_ptr_err),
    .tx_cnt_zero(tx_cnt_zero), .tx_ncnt_zero(tx_ncnt_zero),
    .rx_cnt_zero(rx_cnt_zero), .rx_ncnt_zero(rx_ncnt_zero),
    .tx_cnt_wr(tx_cnt_wr), .rx_cnt_wr(rx_cnt_wr),
    .stat_rd(stat_rd), .stat_rdata(stat_rdata)
  );

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] mask, input logic [31:0] exp);
    nchk++;
    if ((stat_rdata & mask) !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, stat_rdata & mask, exp);
    end
  endtask

  task automatic rd_clear;
    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; fifo_en = 0; spi_en = 0; rdr_load = 0; rdr_read = 0;
    tdr_write = 0; tdr_to_shift = 0; shift_idle = 1; gap_done = 1;
    ev_modf = 0; ev_underrun = 0; ev_cs_rise = 0; ev_frame_err = 0;
    ev_crc_err = 0; ev_match = 0;
    rx_level = '0; tx_level = '0; rx_thres = LW'(4); tx_thres = LW'(4);
    rx_ptr_err = 0; tx_ptr_err = 0;
    tx_cnt_zero = 1; tx_ncnt_zero = 1; rx_cnt_zero = 1; rx_ncnt_zero = 1;
    tx_cnt_wr = 0; rx_cnt_wr = 0; stat_rd = 0;
    @(negedge clk);
    repeat (3) tick();
    chk("R1 in reset", ALL, BASE);
    rst_n = 1;
    tick();
    chk("R1 after reset", ALL, BASE);

    // R2/R4 table walk
    for (int i = 0; i < 8; i++) begin
      logic [5:0]  p;
      logic [31:0] m;
      {p, m} = VEC[i];
      {ev_match, ev_crc_err, ev_frame_err, ev_cs_rise, ev_underrun, ev_modf} = p;
      tick();
      {ev_match, ev_crc_err, ev_frame_err, ev_cs_rise, ev_underrun, ev_modf} = '0;
      chk("R2 set", ALL, BASE | m);
      tick();
      chk("R2 held", ALL, BASE | m);
      stat_rd = 1'b1;
      chk("R4 preclear", ALL, BASE | m);
      tick();
      stat_rd = 1'b0;
      chk("R2 cleared", ALL, BASE);
    end

    // R3 set wins over read
    ev_modf = 1; stat_rd = 1;
    chk("R3 same-cycle word", ALL, BASE);
    tick();
    ev_modf = 0; stat_rd = 0;
    chk("R3 set kept", 32'h4, 32'h4);
    rd_clear();
    chk("R3 later cleared", 32'h4, 32'h0);

    // R5 / R10 overrun and receive ready
    rdr_load = 1; tick(); rdr_load = 0;
    chk("R10 load sets", 32'h9, 32'h1);
    rdr_load = 1; tick(); rdr_load = 0;
    chk("R5 second load", 32'h9, 32'h9);
    rdr_read = 1; tick(); rdr_read = 0;
    chk("R10 read clears", 32'h1, 32'h0);
    rd_clear();
    rdr_load = 1; tick();
    rdr_read = 1; tick();
    rdr_load = 0; rdr_read = 0;
    chk("R5 load with read", 32'h9, 32'h1);
    rdr_read = 1; tick(); rdr_read = 0;

    // R12 levels
    rx_ptr_err = 1; tx_ptr_err = 1; tick();
    chk("R12 ptr err", 32'hC000_0000, 32'hC000_0000);
    rx_ptr_err = 0; tx_ptr_err = 0; tick();
    chk("R12 ptr err low", 32'hC000_0000, 32'h0);

    // R11 end of buffer
    tx_cnt_zero = 0; tx_cnt_wr = 1; tick(); tx_cnt_wr = 0;
    chk("R11 write clears", 32'hA0, 32'h0);
    tx_cnt_zero = 1; tick();
    chk("R11 zero sets", 32'hA0, 32'hA0);
    tx_cnt_wr = 1; tick(); tx_cnt_wr = 0;
    chk("R11 write wins", 32'h20, 32'h0);
    tick();
    chk("R11 reset again", 32'h20, 32'h20);
    rx_ncnt_zero = 0; tick();
    chk("R12 rx buf", 32'h50, 32'h10);
    rx_ncnt_zero = 1; tick();

    // R9 / R8 transmit ready and path empty
    spi_en = 1; tick();
    chk("R9 enable sets", 32'h10202, 32'h10002);
    tick();
    chk("R8 path empty", 32'h202, 32'h202);
    tdr_write = 1; tick(); tdr_write = 0;
    chk("R8 R9 write clears", 32'h202, 32'h0);
    shift_idle = 0; tdr_to_shift = 1; tick(); tdr_to_shift = 0;
    chk("R9 to shifter", 32'h202, 32'h2);
    tick();
    chk("R8 shifter busy", 32'h202, 32'h2);
    shift_idle = 1; gap_done = 0; tick();
    chk("R8 gap pending", 32'h202, 32'h2);
    gap_done = 1; tick();
    chk("R8 gap done", 32'h202, 32'h202);
    spi_en = 0; tick();
    chk("R9 disable", 32'h10002, 32'h0);

    // R10 / R6 FIFO RX
    fifo_en = 1; rx_level = LW'(3); tick();
    chk("R10 fifo rx data", 32'h3800_0001, 32'h1);
    rx_level = LW'(4); tick();
    chk("R6 threshold", 32'h3800_0000, 32'h2000_0000);
    rd_clear();
    chk("R6 cleared", 32'h3800_0000, 32'h0);
    tick();
    chk("R6 no reset on level", 32'h3800_0000, 32'h0);
    rx_level = LW'(DEPTH); tick();
    chk("R6 full", 32'h3800_0000, 32'h1000_0000);
    rx_level = '0; tick();
    chk("R6 empty", 32'h3800_0001, 32'h1800_0000);
    rd_clear();

    // R7 / R9 FIFO TX
    tx_level = LW'(DEPTH); tick();
    chk("R7 tx full", 32'h0700_0002, 32'h0200_0000);
    tx_level = LW'(3); tick();
    chk("R7 tx threshold", 32'h0700_0002, 32'h0600_0002);
    tx_level = '0; tick();
    chk("R7 tx empty", 32'h0700_0000, 32'h0700_0000);
    rd_clear();
    chk("R7 cleared", 32'h0700_0000, 32'h0);

    finish_run();
  end
endmodule